// File: doc/BRIEF.md
# Half-Bridge Gate Command Controller

This block sits between a PWM generator and the two gate drivers of one half-bridge leg. It takes an active-high command for the high-side switch and one for the low-side switch, and produces a gate-enable for each. Both commands are in phase: a high command asks for its gate on, and a low command leaves it off. Every command edge passes through a two-flop synchronizer and a persistence filter, so short spikes never reach a gate.

In the profiles with protection, the controller never lets both gates be on at once. It also holds a fixed dead gap after any gate switches off. Two digital supply-good flags, one for the low-side rail and one for the floating high-side rail, are deglitched and gate the outputs. The two sides return from a supply fault differently. The low side picks up its command level at once. The high side waits for a fresh rising command edge.

A compile-time profile sets the filter length, the dead gap and whether the interlock exists. All times are counted in cycles of the single clock, which is nominally 100 MHz.

Top module: `hb_gate_ctrl`

## Requirements
- R1: During reset both gates are low, and they stay low until the supply flags have qualified and a command asks for a gate.
- R2: A command level change must persist for the profile's filter count before it is accepted. Shorter pulses of either polarity are dropped. An unblocked change reaches its gate after exactly filter count + 3 rising clock edges.
- R3: A dip on a supply flag that is shorter than SUPPLY_FILT_CYC cycles has no effect on either gate.
- R4: In the protected profiles the two gates are never high in the same cycle. While both filtered commands are high, both gates are driven low.
- R5: In the protected profiles, no gate rises within the dead count of cycles after any gate falls. A direct swap from one side to the other shows a gap of exactly the dead count.
- R6: While the qualified low-side supply flag is low, both gates are low.
- R7: While the qualified high-side supply flag is low, the high-side gate is low.
- R8: After either supply flag has been lost, the high-side gate stays low until its command shows a new rising edge, even when the command is held high throughout.
- R9: When the low-side supply flag recovers, the low-side gate takes its command level without needing an edge. It rises SUPPLY_FILT_CYC + 3 edges after the flag returns.
- R10: In the bare profile (encoding 2) there is no interlock and no dead gap, and both gates may be on together.
- R11: Profile encodings and cycle counts: 0 gives filter 8 and dead 8; 1 gives filter 20 and dead 38; 2 gives filter 20 and dead 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Active-low reset |
| hsCmd | input | 1 | High-side switch command, active high |
| lsCmd | input | 1 | Low-side switch command, active high |
| lsSupplyOk | input | 1 | Low-side rail good flag (high means good) |
| hsSupplyOk | input | 1 | Floating high-side rail good flag (high means good) |
| hsGate | output | 1 | High-side gate enable |
| lsGate | output | 1 | Low-side gate enable |

## Verification
Two functions can act in the same cycle: the interlock reacting to a second command, and the dead-gap counter still running after a gate fell. A command swap in which one command falls while the other rises provokes them together, because both filters accept their new levels on the same edge. The swap is judged by the measured latency of the falling gate and the exact gap before the other gate rises. Random command traffic then runs against a per-cycle monitor of gate overlap and of the gap since the last falling gate. A held-high command across a high-side supply fault shows that re-arming needs an edge.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

  typedef enum logic [1:0] {
    PROF_FET  = 2'd0,
    PROF_IGBT = 2'd1,
    PROF_BARE = 2'd2
  } hbProfile_e;

  typedef struct packed {
    logic hoSet;
    logic hoClr;
    logic loSet;
    logic loClr;
    logic deadLoad;
  } gateStrobe_t;

  function automatic int unsigned profFiltCyc(hbProfile_e p);
    case (p)
      PROF_FET: return 8;
      default:  return 20;
    endcase
  endfunction

  function automatic int unsigned profDeadCyc(hbProfile_e p);
    case (p)
      PROF_FET:  return 8;
      PROF_IGBT: return 38;
      default:   return 0;
    endcase
  endfunction

  function automatic bit profInterlock(hbProfile_e p);
    return (p != PROF_BARE);
  endfunction

endpackage

// File: rtl/hb_level_filter.sv
module hb_level_filter #(
  parameter int unsigned CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rawIn,
  output logic filtOut
);
  localparam int unsigned CNT_W = (CYC < 2) ? 1 : $clog2(CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC - 1);

  logic [1:0]       syncQ;
  logic [CNT_W-1:0] runCnt;
  logic             filtQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ  <= 2'b00;
      runCnt <= '0;
      filtQ  <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] != filtQ) begin
        if (runCnt == LAST) begin
          filtQ  <= syncQ[1];
          runCnt <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end else begin
        runCnt <= '0;
      end
    end
  end

  assign filtOut = filtQ;

  // R2: an accepted level is the synchronized level after a full run
  p_filter_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (filtQ != $past(filtQ)) |-> ($past(syncQ[1]) == filtQ))
    else $error("filter accepted a level it did not see");
  p_filter_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (filtQ != $past(filtQ)) |-> ($past(runCnt) == LAST))
    else $error("filter accepted before full count");

endmodule

// File: rtl/hb_gate_dp.sv
module hb_gate_dp
  import hb_gate_pkg::*;
#(
  parameter int unsigned FILT_CYC = 8,
  parameter int unsigned DEAD_CYC = 8,
  parameter int unsigned SUP_CYC  = 180
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hinRaw,
  input  logic        linRaw,
  input  logic        vddOkRaw,
  input  logic        vbsOkRaw,
  input  gateStrobe_t strobe,
  output logic        hinF,
  output logic        linF,
  output logic        vddOkF,
  output logic        vbsOkF,
  output logic        hoOut,
  output logic        loOut,
  output logic        deadDone
);
  localparam int unsigned NCH = 4;

  logic [NCH-1:0] rawVec;
  logic [NCH-1:0] filtVec;

  assign rawVec = {vbsOkRaw, vddOkRaw, linRaw, hinRaw};

  for (genvar g = 0; g < NCH; g++) begin : g_filt
    localparam int unsigned CH_CYC = (g < 2) ? FILT_CYC : SUP_CYC;
    hb_level_filter #(.CYC(CH_CYC)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .rawIn  (rawVec[g]),
      .filtOut(filtVec[g])
    );
  end

  assign hinF   = filtVec[0];
  assign linF   = filtVec[1];
  assign vddOkF = filtVec[2];
  assign vbsOkF = filtVec[3];

  logic hoQ, loQ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hoQ <= 1'b0;
      loQ <= 1'b0;
    end else begin
      if (strobe.hoClr)      hoQ <= 1'b0;
      else if (strobe.hoSet) hoQ <= 1'b1;
      if (strobe.loClr)      loQ <= 1'b0;
      else if (strobe.loSet) loQ <= 1'b1;
    end
  end
  assign hoOut = hoQ;
  assign loOut = loQ;

  if (DEAD_CYC > 0) begin : g_dead
    localparam int unsigned DC_W = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);
    localparam logic [DC_W-1:0] RELOAD = DC_W'(DEAD_CYC - 1);
    logic [DC_W-1:0] deadCnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               deadCnt <= '0;
      else if (strobe.deadLoad) deadCnt <= RELOAD;
      else if (deadCnt != '0)   deadCnt <= deadCnt - 1'b1;
    end
    assign deadDone = (deadCnt == '0);

    // R5: a falling gate restarts the dead window from its full length
    p_dead_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(hoQ) || $fell(loQ)) |-> (deadCnt == RELOAD))
      else $error("dead window not restarted on gate fall");
  end else begin : g_nodead
    assign deadDone = 1'b1;
  end

endmodule

// File: rtl/hb_gate_ctl.sv
module hb_gate_ctl
  import hb_gate_pkg::*;
#(
  parameter bit INTERLOCK = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hinF,
  input  logic        linF,
  input  logic        vddOkF,
  input  logic        vbsOkF,
  input  logic        hoOut,
  input  logic        loOut,
  input  logic        deadDone,
  output gateStrobe_t strobe
);
  logic hinPrev;
  logic hsArmed;
  logic supplyOk;
  logic hinRise;
  logic hsReq, lsReq;

  assign supplyOk = vddOkF & vbsOkF;
  assign hinRise  = hinF & ~hinPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hinPrev <= 1'b0;
      hsArmed <= 1'b0;
    end else begin
      hinPrev <= hinF;
      if (!supplyOk)    hsArmed <= 1'b0;
      else if (hinRise) hsArmed <= 1'b1;
    end
  end

  assign hsReq = hinF & (hsArmed | hinRise) & supplyOk;
  assign lsReq = linF & vddOkF;

  if (INTERLOCK) begin : g_lock
    logic bothReq, hsGo, lsGo;
    assign bothReq = hsReq & lsReq;
    assign hsGo    = hsReq & ~bothReq;
    assign lsGo    = lsReq & ~bothReq;
    always_comb begin
      strobe.hoClr    = hoOut & ~hsGo;
      strobe.loClr    = loOut & ~lsGo;
      strobe.hoSet    = ~hoOut & hsGo & ~loOut & deadDone;
      strobe.loSet    = ~loOut & lsGo & ~hoOut & deadDone;
      strobe.deadLoad = strobe.hoClr | strobe.loClr;
    end

    // R4: gates never overlap
    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(hoOut && loOut))
      else $error("both gates high");
    // R5: a gate only rises from a cycle where the other was low
    p_rise_from_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hoOut) || $rose(loOut)) |-> (!$past(hoOut) && !$past(loOut)))
      else $error("gate rose without idle cycle");
  end else begin : g_free
    always_comb begin
      strobe.hoClr    = hoOut & ~hsReq;
      strobe.loClr    = loOut & ~lsReq;
      strobe.hoSet    = ~hoOut & hsReq;
      strobe.loSet    = ~loOut & lsReq;
      strobe.deadLoad = 1'b0;
    end
  end

  // R6: low-side undervoltage forces both gates off next cycle
  p_uvlo_ls_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !vddOkF |=> (!hoOut && !loOut))
    else $error("gate on during low-side undervoltage");
  // R7: high-side undervoltage forces the high gate off next cycle
  p_uvlo_hs_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !vbsOkF |=> !hoOut)
    else $error("high gate on during high-side undervoltage");
  // R8: a rising high gate is always backed by an armed edge
  p_hs_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hoOut) |-> hsArmed)
    else $error("high gate rose without edge arming");

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_gate_pkg::*;
#(
  parameter hbProfile_e  PROFILE         = PROF_FET,
  parameter int unsigned SUPPLY_FILT_CYC = 180
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsCmd,
  input  logic lsCmd,
  input  logic lsSupplyOk,
  input  logic hsSupplyOk,
  output logic hsGate,
  output logic lsGate
);
  localparam int unsigned FILT_CYC  = profFiltCyc(PROFILE);
  localparam int unsigned DEAD_CYC  = profDeadCyc(PROFILE);
  localparam bit          INTERLOCK = profInterlock(PROFILE);

  gateStrobe_t strobe;
  logic hinF, linF, vddOkF, vbsOkF, hoOut, loOut, deadDone;

  hb_gate_dp #(
    .FILT_CYC(FILT_CYC),
    .DEAD_CYC(DEAD_CYC),
    .SUP_CYC (SUPPLY_FILT_CYC)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .hinRaw  (hsCmd),
    .linRaw  (lsCmd),
    .vddOkRaw(lsSupplyOk),
    .vbsOkRaw(hsSupplyOk),
    .strobe  (strobe),
    .hinF    (hinF),
    .linF    (linF),
    .vddOkF  (vddOkF),
    .vbsOkF  (vbsOkF),
    .hoOut   (hoOut),
    .loOut   (loOut),
    .deadDone(deadDone)
  );

  hb_gate_ctl #(.INTERLOCK(INTERLOCK)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .hinF    (hinF),
    .linF    (linF),
    .vddOkF  (vddOkF),
    .vbsOkF  (vbsOkF),
    .hoOut   (hoOut),
    .loOut   (loOut),
    .deadDone(deadDone),
    .strobe  (strobe)
  );

  assign hsGate = hoOut;
  assign lsGate = loOut;

endmodule

// File: tb/hb_gate_ctrl_tb.sv
`timescale 1ns/1ps
module hb_gate_ctrl_tb;
  import hb_gate_pkg::*;

  localparam int F  = 8;    // R11: profile 0 filter count
  localparam int D  = 8;    // R11: profile 0 dead count
  localparam int FB = 20;   // R11: profile 2 filter count
  localparam int S  = 180;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsCmd = 1'b0, lsCmd = 1'b0, lsSupplyOk = 1'b0, hsSupplyOk = 1'b0;
  logic hsGate, lsGate, hsGateB, lsGateB;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hb_gate_ctrl #(.PROFILE(PROF_FET), .SUPPLY_FILT_CYC(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .hsCmd(hsCmd), .lsCmd(lsCmd),
    .lsSupplyOk(lsSupplyOk), .hsSupplyOk(hsSupplyOk),
    .hsGate(hsGate), .lsGate(lsGate));

  hb_gate_ctrl #(.PROFILE(PROF_BARE), .SUPPLY_FILT_CYC(S)) u_dut_bare (
    .clk(clk), .rst_n(rst_n), .hsCmd(hsCmd), .lsCmd(lsCmd),
    .lsSupplyOk(lsSupplyOk), .hsSupplyOk(hsSupplyOk),
    .hsGate(hsGateB), .lsGate(lsGateB));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int expLatency(input int filt);
    return filt + 3;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // per-cycle monitor of overlap and dead gap (R4, R5)
  bit hoP = 0, loP = 0, fellSeen = 0;
  int sinceFall = 0;
  bit monOn = 0;
  always @(negedge clk) begin
    if (rst_n && monOn) begin
      sinceFall++;
      chk(!(hsGate && lsGate), "R4 overlap", {hsGate, lsGate}, 0);
      if ((hoP && !hsGate) || (loP && !lsGate)) begin
        sinceFall = 0;
        fellSeen = 1;
      end
      if (fellSeen && ((!hoP && hsGate) || (!loP && lsGate)))
        chk(sinceFall >= D, "R5 dead gap", sinceFall, D);
    end
    hoP = hsGate;
    loP = lsGate;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int lat, tFall, tRise;
    bit seen, held;
    // R1 reset
    cyc(5);
    chk(!hsGate && !lsGate, "R1 reset", {hsGate, lsGate}, 0);
    @(negedge clk) rst_n = 1'b1;
    hsCmd = 1'b1;
    cyc(20);
    chk(!hsGate, "R1 no supply", hsGate, 0);
    hsCmd = 1'b0;
    lsSupplyOk = 1'b1;
    hsSupplyOk = 1'b1;
    cyc(S + 10);
    chk(!hsGate && !lsGate, "R1 idle", {hsGate, lsGate}, 0);
    monOn = 1;

    // R2 / R11: latency of low command
    lsCmd = 1'b1;
    lat = 0;
    while (!lsGate && lat < 200) begin @(negedge clk); lat++; end
    chk(lat == expLatency(F), "R2 R11 latency", lat, expLatency(F));

    // R5 swap lo->hi
    lsCmd = 1'b0; hsCmd = 1'b1;
    tFall = 0; tRise = 0;
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      if (tFall == 0 && !lsGate) tFall = i;
      if (tRise == 0 && hsGate) tRise = i;
    end
    chk(tFall == expLatency(F), "R2 fall latency", tFall, expLatency(F));
    chk(tRise - tFall == D, "R5 swap gap", tRise - tFall, D);

    // R5 swap hi->lo
    hsCmd = 1'b0; lsCmd = 1'b1;
    tFall = 0; tRise = 0;
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      if (tFall == 0 && !hsGate) tFall = i;
      if (tRise == 0 && lsGate) tRise = i;
    end
    chk(tRise - tFall == D, "R5 swap back gap", tRise - tFall, D);

    // R2 short low glitch is dropped
    lsCmd = 1'b0; cyc(F - 1); lsCmd = 1'b1;
    held = 1;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (!lsGate) held = 0; end
    chk(held, "R2 short low pulse", held, 1);

    // R4 both high: both off; R10 bare: both on
    hsCmd = 1'b1;
    cyc(40);
    chk(!hsGate && !lsGate, "R4 both cmd", {hsGate, lsGate}, 0);
    chk(hsGateB && lsGateB, "R10 bare both", {hsGateB, lsGateB}, 3);

    // R8 edge seen while blocked keeps high side armed
    lsCmd = 1'b0;
    cyc(F + D + 12);
    chk(hsGate && !lsGate, "R8 armed after lock", {hsGate, lsGate}, 2);

    // R7 / R8 high-side supply loss
    hsSupplyOk = 1'b0;
    cyc(S + 10);
    chk(!hsGate, "R7 hs uv", hsGate, 0);
    hsSupplyOk = 1'b1;
    cyc(S + 40);
    chk(!hsGate, "R8 no edge no gate", hsGate, 0);
    chk(!hsGateB, "R8 bare no edge", hsGateB, 0);
    hsCmd = 1'b0; cyc(F + 5); hsCmd = 1'b1;
    cyc(F + D + 12);
    chk(hsGate, "R8 fresh edge", hsGate, 1);

    // R3 short supply dip ignored
    lsSupplyOk = 1'b0; cyc(S - 20); lsSupplyOk = 1'b1;
    held = 1;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (!hsGate) held = 0; end
    chk(held, "R3 short dip", held, 1);

    // R6 / R9 low-side supply loss and level recovery
    hsCmd = 1'b0; lsCmd = 1'b1;
    cyc(40);
    chk(lsGate, "R9 pre", lsGate, 1);
    lsSupplyOk = 1'b0;
    cyc(S + 10);
    chk(!hsGate && !lsGate, "R6 ls uv", {hsGate, lsGate}, 0);
    hsCmd = 1'b1; lsCmd = 1'b0; cyc(F + 5); hsCmd = 1'b0; lsCmd = 1'b1;
    cyc(F + 5);
    chk(!hsGate && !lsGate, "R6 cmds ignored", {hsGate, lsGate}, 0);
    lsSupplyOk = 1'b1;
    lat = 0;
    while (!lsGate && lat < 400) begin @(negedge clk); lat++; end
    chk(lat == S + 3, "R9 recovery", lat, S + 3);

    // R2 pulse boundaries from idle
    lsCmd = 1'b0; cyc(40);
    lsCmd = 1'b1; cyc(F - 1); lsCmd = 1'b0;
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (lsGate) seen = 1; end
    chk(!seen, "R2 short high pulse", seen, 0);
    lsCmd = 1'b1; cyc(F); lsCmd = 1'b0;
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (lsGate) seen = 1; end
    chk(seen, "R2 full pulse", seen, 1);
    // R10 bare profile lets a full pulse through at its own latency
    lsCmd = 1'b1;
    lat = 0;
    while (!lsGateB && lat < 200) begin @(negedge clk); lat++; end
    chk(lat == expLatency(FB), "R10 R11 bare latency", lat, expLatency(FB));

    // random traffic under the monitor
    void'($urandom(32'h5eed_0042));
    for (int it = 0; it < 2000; it++) begin
      hsCmd = 1'($urandom_range(0, 1));
      lsCmd = 1'($urandom_range(0, 1));
      cyc($urandom_range(1, 40));
    end
    hsCmd = 1'b0; lsCmd = 1'b0;
    cyc(40);
    chk(!hsGate && !lsGate, "R1 end idle", {hsGate, lsGate}, 0);
    summary();
  end

endmodule